// File: doc/BRIEF.md
# Ones'-Complement Count-Compare-Skip Unit

This execution unit carries out the arithmetic and branch decision of a count, compare and skip instruction on 15-bit ones'-complement words. When the sequencer pulses the start strobe, the unit takes the operand word that was read from memory and sorts it into one of four classes: positive, plus zero, negative or minus zero. It then forms the diminished absolute value. This is the magnitude of the operand reduced by one, and it never goes below plus zero.

The diminished value is returned as the new 16-bit accumulator contents, sign-extended so that its two top bits agree. The unit also returns a program-counter skip offset from 1 to 4, which the sequencer adds to select one of four following instruction words. Both outputs are registered. They appear one clock after the strobe, together with a single-cycle done pulse. Fetch, memory access and the program-counter update stay outside the unit.

Top module: `ccs_unit`

## Requirements
- R1: While reset is asserted, result_o is 0, skip_o is 0 and done_o is 0.
- R2: An operand with bit 14 clear that is not all zeros is positive: result_o becomes the operand minus one, zero-extended to 16 bits, and skip_o becomes 1.
- R3: The operand 15'h0000 (plus zero) gives result_o = 0 and skip_o = 2.
- R4: An operand with bit 14 set that is not all ones is negative: result_o becomes the 15-bit bitwise complement of the operand minus one, and skip_o becomes 3.
- R5: The operand 15'h7FFF (minus zero) gives result_o = 0 and skip_o = 4.
- R6: result_o and skip_o take their new values at the rising edge that samples start_i high. done_o is high for exactly the cycle that follows that edge.
- R7: result_o bits 15 and 14 are always equal, and both are 0, because the diminished absolute value is never negative.
- R8: While start_i is low, operand_i is ignored. result_o and skip_o keep their last values, and done_o is low.
- R9: The extreme operands saturate correctly. 15'h3FFF (largest positive) gives 16'h3FFE with skip 1, and 15'h4000 (most negative) gives 16'h3FFE with skip 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue strobe; samples operand_i |
| operand_i | input | 15 | Ones'-complement operand, sign in bit 14 |
| result_o | output | 16 | Diminished absolute value, sign-extended |
| skip_o | output | 3 | Skip offset 1..4 (0 after reset) |
| done_o | output | 1 | One-cycle pulse, result valid |

## Verification
If the classifier holds a wrong state, skip_o shows the wrong offset in the done cycle, one clock after the strobe. The zero classes are the sensitive points. If the all-ones pattern is treated as negative, skip 3 appears where 4 is expected. If a zero is treated as positive, the decrement wraps and result_o shows a large value instead of 0. A fault in the magnitude path shows up as result_o differing by one or by the complement in that same cycle. A fault in the hold logic shows up as output movement in the cycles between strobes.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned SKIP_W = 3;

  typedef enum logic [1:0] {
    CLS_POS   = 2'd0,
    CLS_PZERO = 2'd1,
    CLS_NEG   = 2'd2,
    CLS_MZERO = 2'd3
  } op_class_e;

  // class order equals branch order: offset = class + 1
  function automatic logic [SKIP_W-1:0] class_to_skip(op_class_e c);
    return {1'b0, c} + 3'd1;
  endfunction
endpackage

// File: rtl/ccs_classify.sv
module ccs_classify
  import ccs_pkg::*;
#(
  parameter int unsigned DATA_W = 15
) (
  input  logic [DATA_W-1:0] word_i,
  output op_class_e         cls_o
);
  logic is_pzero, is_mzero, sign;

  assign sign     = word_i[DATA_W-1];
  assign is_pzero = (word_i == '0);
  assign is_mzero = (word_i == '1);

  always_comb begin
    if (is_pzero)      cls_o = CLS_PZERO;
    else if (is_mzero) cls_o = CLS_MZERO;
    else if (sign)     cls_o = CLS_NEG;
    else               cls_o = CLS_POS;
  end
endmodule

// File: rtl/ccs_dabs.sv
module ccs_dabs #(
  parameter int unsigned DATA_W = 15
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dabs_o
);
  logic [DATA_W-1:0] mag;

  // ones' complement magnitude; both zeros map to all-zero
  assign mag = word_i[DATA_W-1] ? ~word_i : word_i;

  always_comb begin
    if (mag == '0) dabs_o = '0;
    else           dabs_o = mag - {{(DATA_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/ccs_unit.sv
module ccs_unit
  import ccs_pkg::*;
#(
  parameter int unsigned DATA_W = 15,
  parameter int unsigned ACC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [ACC_W-1:0]  result_o,
  output logic [SKIP_W-1:0] skip_o,
  output logic              done_o
);
  localparam int unsigned EXT_W = ACC_W - DATA_W;

  op_class_e         cls;
  logic [DATA_W-1:0] dabs;
  logic [ACC_W-1:0]  acc_d;
  logic [ACC_W-1:0]  result_q;
  logic [SKIP_W-1:0] skip_q;
  logic              done_q;

  ccs_classify #(.DATA_W(DATA_W)) u_cls (
    .word_i (operand_i),
    .cls_o  (cls)
  );

  ccs_dabs #(.DATA_W(DATA_W)) u_dabs (
    .word_i (operand_i),
    .dabs_o (dabs)
  );

  assign acc_d = {{EXT_W{dabs[DATA_W-1]}}, dabs};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      skip_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        result_q <= acc_d;
        skip_q   <= class_to_skip(cls);
      end
    end
  end

  assign result_o = result_q;
  assign skip_o   = skip_q;
  assign done_o   = done_q;
endmodule

// File: rtl/ccs_unit_chk.sv
module ccs_unit_chk
  import ccs_pkg::*;
#(
  parameter int unsigned DATA_W = 15,
  parameter int unsigned ACC_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [ACC_W-1:0]  result_o,
  input logic [SKIP_W-1:0] skip_o,
  input logic              done_o
);
  a_r6_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  a_r8_no_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(skip_o)));
  a_r7_top_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[ACC_W-1] == 1'b0) && (result_o[ACC_W-2] == 1'b0));
  a_r3_plus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && operand_i == '0) |=> (result_o == '0 && skip_o == 3'd2));
  a_r5_minus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && operand_i == '1) |=> (result_o == '0 && skip_o == 3'd4));
  a_r2_positive_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !operand_i[DATA_W-1] && operand_i != '0) |=> (skip_o == 3'd1));
  a_r4_negative_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && operand_i[DATA_W-1] && operand_i != '1) |=> (skip_o == 3'd3));
endmodule

bind ccs_unit ccs_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .operand_i (operand_i),
  .result_o  (result_o),
  .skip_o    (skip_o),
  .done_o    (done_o)
);

// File: tb/ccs_unit_test.sv
module ccs_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] operand_i = '0;
  logic [15:0] result_o;
  logic [2:0]  skip_o;
  logic        done_o;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ccs_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .operand_i(operand_i),
    .result_o(result_o), .skip_o(skip_o), .done_o(done_o)
  );

  function automatic logic [15:0] exp_res(logic [14:0] w);
    logic [14:0] m;
    m = w[14] ? ~w : w;
    if (m == 15'd0) return 16'd0;
    return {1'b0, m - 15'd1};
  endfunction

  function automatic logic [2:0] exp_skip(logic [14:0] w);
    if (w == 15'h0000) return 3'd2;
    if (w == 15'h7FFF) return 3'd4;
    if (w[14])         return 3'd3;
    return 3'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [14:0] w, string req);
    logic [15:0] er;
    logic [2:0]  es;
    er = exp_res(w);
    es = exp_skip(w);
    @(negedge clk_i);
    start_i = 1'b1; operand_i = w;
    @(negedge clk_i);
    start_i = 1'b0; operand_i = 15'($urandom);
    chk({req, " result"}, 32'(result_o), 32'(er));
    chk({req, " skip"},   32'(skip_o),   32'(es));
    chk("R6 done pulse",  32'(done_o),   32'd1);
    chk("R7 top bits",    32'(result_o[15:14]), 32'd0);
    @(negedge clk_i);
    chk("R8 hold result", 32'(result_o), 32'(er));
    chk("R8 hold skip",   32'(skip_o),   32'(es));
    chk("R6 done single", 32'(done_o),   32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk_i);
    chk("R1 reset result", 32'(result_o), 32'd0);
    chk("R1 reset skip",   32'(skip_o),   32'd0);
    chk("R1 reset done",   32'(done_o),   32'd0);
    rst_ni = 1'b1;
    apply(15'h0001, "R2 plus one");
    apply(15'h7FFE, "R4 minus one");
    apply(15'h0000, "R3 plus zero");
    apply(15'h7FFF, "R5 minus zero");
    apply(15'h3FFF, "R9 max positive");
    apply(15'h4000, "R9 most negative");
    apply(15'h0002, "R2 plus two");
    apply(15'h7FFD, "R4 minus two");
    // idle with toggling operand: R8
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      operand_i = 15'($urandom);
      chk("R8 idle result", 32'(result_o), 32'h3FFE ^ 32'h3FFE ^ 32'(exp_res(15'h7FFD)));
      chk("R8 idle done", 32'(done_o), 32'd0);
    end
    for (int i = 0; i < 300; i++) begin
      logic [14:0] w;
      case ($urandom % 8)
        0: w = 15'h0000;
        1: w = 15'h7FFF;
        default: w = 15'($urandom);
      endcase
      apply(w, w[14] ? "R4 random" : "R2 random");
    end
    // back-to-back strobes: R6
    @(negedge clk_i);
    start_i = 1'b1; operand_i = 15'h0005;
    @(negedge clk_i);
    operand_i = 15'h7FFF;
    chk("R6 b2b result", 32'(result_o), 32'h4);
    chk("R6 b2b done", 32'(done_o), 32'd1);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R5 b2b skip", 32'(skip_o), 32'd4);
    chk("R6 b2b done2", 32'(done_o), 32'd1);
    @(negedge clk_i);
    chk("R6 b2b done end", 32'(done_o), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule